// File: doc/BRIEF.md
# Punched Card Reader Controller

This controller sits between a word-wide CPU I/O bus and a punched-card reader. Software writes an 18-bit control word to set an interrupt channel, arm interrupt enables, clear conditions or start a card. It reads back an 18-bit status word. Once a card is started, the controller paces itself with an internal interval counter. At the first interval it asks the card source for a new card. At each following interval it takes one 12-bit column into a data register. After the last column it reports end-of-card.

The host does not pace the column flow. A column that has not been read when the next one lands sets a sticky data-miss flag. Ready-to-read is not stored. It is derived from the presence of a card source and the absence of any card activity. Interrupt requests go out on the programmed channel. Channel 0 means no request.

Top module: `card_reader_ctl`

## Requirements
- R1: After reset every status bit is zero, except two. Ready-to-read (octal 010) is high while `src_present` is high. Hopper-empty (octal 02000) is high while `src_present` is low.
- R2: Every control write without the clear-reader bit loads control bits [2:0] into the interrupt channel. The channel reads back in status bits [2:0] and on `irq_chan`. While the channel is 0, `irq_req` stays low.
- R3: Control bit 0100 sets the ready-interrupt enable (status 0200000). Control bit 0400 sets the trouble-interrupt enable (status 0400000). Both stay set until a clear-reader command. The offset bit 04000 has no effect on status or interrupts.
- R4: Control bit 010000 (clear reader) zeroes all stored state, the channel included, and cancels any card in progress. No other bit of that word takes effect.
- R5: Ready-to-read is high whenever `src_present` is high and none of reading (01000), card-in-reader (04000) or end-of-card (020) is set. Ready-to-read together with its enable requests an interrupt.
- R6: Control bit 01000 (read) sets reading and clears card-in-reader, data-ready (0100) and the column count. The card pick (`src_pick`) follows one pacing interval later.
- R7: While a card is in the reader, each pacing interval of PACE_CYCLES cycles takes the next column (`src_take`). The column goes into the data register, data-ready is set and an interrupt is pending. The 80 columns arrive in source order.
- R8: Loading a column while data-ready is still set, and no data read is taking place in that cycle, sets data-miss (0200). Data-miss stays set until control bit 0200 or clear-reader.
- R9: One interval after the last column, reading and card-in-reader clear, end-of-card (020) sets, and an interrupt is pending.
- R10: At the pick, `src_eof` sets end-file (040) and `src_err` sets trouble (0400). If both are high, end-file wins. Either one clears reading, and no card is loaded.
- R11: With the trouble enable set, any of end-of-card, end-file, data-miss or trouble requests an interrupt.
- R12: A data read (`rd_en`) returns the column on `rd_data` when data-ready is set and returns zero otherwise. It clears data-ready and the pending interrupt.
- R13: Control bits 010, 020 and 040 clear data-ready, end-of-card and end-file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 18 | Control word |
| stat_word | output | 18 | Status word |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 12 | Column read data, zero when no column is ready |
| irq_req | output | 1 | Interrupt request |
| irq_chan | output | 3 | Interrupt channel of the request |
| src_present | input | 1 | A card source is present |
| src_pick | output | 1 | One-cycle request for a new card; eof and error are sampled in this cycle |
| src_take | output | 1 | One-cycle column take; `src_col` is sampled in this cycle |
| src_col | input | 12 | Current column from the source |
| src_eof | input | 1 | Source has no more cards |
| src_err | input | 1 | Source read error |

## Verification
A whole card is read with every column consumed promptly. This separates correct column order and interval spacing from a counter that skips, repeats or misses the end-of-card step. A second card is left unread, so the miss flag, its stickiness and the trouble interrupt show up apart from the prompt case. End-of-file, error and both together are injected at the pick to tell the pick outcomes apart. A table of control words covers channel, enables, offset and clear, including clear with other bits set.

// File: rtl/card_reader_ctl.sv
module card_reader_ctl #(
  parameter int COL_W       = 12,
  parameter int COLS        = 80,
  parameter int PACE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [17:0]      ctl_data,
  output logic [17:0]      stat_word,
  input  logic             rd_en,
  output logic [COL_W-1:0] rd_data,
  output logic             irq_req,
  output logic [2:0]       irq_chan,
  input  logic             src_present,
  output logic             src_pick,
  output logic             src_take,
  input  logic [COL_W-1:0] src_col,
  input  logic             src_eof,
  input  logic             src_err
);
  localparam int CNT_W = $clog2(COLS + 1);
  localparam int TMR_W = $clog2(PACE_CYCLES + 1);

  logic [2:0]       chan;
  logic             rdy_en, trb_en, reading, card_in, end_card, end_file;
  logic             data_rdy, data_miss, trouble, irq_pend;
  logic [COL_W-1:0] col_reg;
  logic [CNT_W-1:0] col_cnt;
  logic [TMR_W-1:0] timer;

  wire cmd_clear = ctl_we & ctl_data[12];
  wire cmd       = ctl_we & ~ctl_data[12];
  wire tick      = reading && (timer == TMR_W'(PACE_CYCLES - 1));
  wire last_done = tick & card_in & (col_cnt == CNT_W'(COLS));
  wire ready     = src_present & ~reading & ~card_in & ~end_card;
  wire trb_cond  = end_card | end_file | data_miss | trouble;
  wire unused_ctl = &{1'b0, ctl_data[17:13], ctl_data[11:10]};

  assign src_pick = tick & ~card_in;
  assign src_take = tick & card_in & (col_cnt != CNT_W'(COLS));
  assign rd_data  = data_rdy ? col_reg : '0;
  assign irq_chan = chan;
  assign irq_req  = (chan != 3'd0) &
                    (irq_pend | (ready & rdy_en) | (trb_en & trb_cond));

  assign stat_word = {trb_en, rdy_en, 4'b0000, card_in, ~src_present,
                      reading, trouble, data_miss, data_rdy, end_file,
                      end_card, ready, chan};

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_clear) begin
      chan <= '0; rdy_en <= 1'b0; trb_en <= 1'b0; reading <= 1'b0;
      card_in <= 1'b0; end_card <= 1'b0; end_file <= 1'b0;
      data_rdy <= 1'b0; data_miss <= 1'b0; trouble <= 1'b0;
      irq_pend <= 1'b0; col_reg <= '0; col_cnt <= '0; timer <= '0;
    end else begin
      timer    <= (reading && !tick) ? timer + 1'b1 : '0;
      irq_pend <= src_take | last_done | (irq_pend & ~rd_en & ~cmd);
      if (rd_en) data_rdy <= 1'b0;
      if (src_pick) begin
        if (src_eof) begin
          end_file <= 1'b1;
          reading  <= 1'b0;
        end else if (src_err) begin
          trouble <= 1'b1;
          reading <= 1'b0;
        end else begin
          card_in <= 1'b1;
        end
      end
      if (src_take) begin
        col_reg  <= src_col;
        col_cnt  <= col_cnt + 1'b1;
        data_rdy <= 1'b1;
        if (data_rdy && !rd_en) data_miss <= 1'b1;
      end
      if (last_done) begin
        card_in  <= 1'b0;
        reading  <= 1'b0;
        end_card <= 1'b1;
      end
      if (cmd) begin
        chan <= ctl_data[2:0];
        if (ctl_data[3]) data_rdy  <= 1'b0;
        if (ctl_data[4]) end_card  <= 1'b0;
        if (ctl_data[5]) end_file  <= 1'b0;
        if (ctl_data[6]) rdy_en    <= 1'b1;
        if (ctl_data[7]) data_miss <= 1'b0;
        if (ctl_data[8]) trb_en    <= 1'b1;
        if (ctl_data[9]) begin
          reading  <= 1'b1;
          card_in  <= 1'b0;
          data_rdy <= 1'b0;
          col_cnt  <= '0;
          timer    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/card_reader_chk.sv
module card_reader_chk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [17:0]      ctl_data,
  input logic [17:0]      stat_word,
  input logic             rd_en,
  input logic [COL_W-1:0] rd_data,
  input logic             irq_req,
  input logic             src_pick,
  input logic             src_take
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we & ctl_data[12] |=> (stat_word & 18'o775767) == 18'o0); // R4

  AST_READ_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we & ctl_data[9] & ~ctl_data[12] |=> stat_word[9] & ~stat_word[11] & ~stat_word[6]); // R6

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[7] & ~(ctl_we & (ctl_data[7] | ctl_data[12])) |=> stat_word[7]); // R8

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en & ~stat_word[6] |-> rd_data == '0); // R12

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en & ~src_take |=> ~stat_word[6]); // R12

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_pick && src_take)); // R7

  AST_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[2:0] == 3'd0 |-> !irq_req); // R2

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[3] |-> ~stat_word[9] & ~stat_word[11]); // R5
endmodule

bind card_reader_ctl card_reader_chk #(.COL_W(COL_W)) i_chk (.*);

// File: tb/test_card_reader_ctl.sv
`timescale 1ns/1ps
module test_card_reader_ctl;
  localparam int PACE = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_we = 1'b0, rd_en = 1'b0;
  logic [17:0] ctl_data = '0;
  logic [17:0] stat_word;
  logic [11:0] rd_data, src_col;
  logic        irq_req, src_pick, src_take;
  logic [2:0]  irq_chan;
  logic        src_present = 1'b1, src_eof = 1'b0, src_err = 1'b0;
  int          errors = 0, checks = 0, cyc = 0, idx = 0;
  bit          done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] colv(input int k);
    return 12'((k * 293 + 17) % 4096);
  endfunction

  always @(posedge clk) begin
    if (src_pick) idx <= 0;
    else if (src_take) idx <= idx + 1;
  end
  assign src_col = colv(idx);

  card_reader_ctl #(.PACE_CYCLES(PACE)) i_card_reader_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .stat_word(stat_word), .rd_en(rd_en), .rd_data(rd_data),
    .irq_req(irq_req), .irq_chan(irq_chan), .src_present(src_present),
    .src_pick(src_pick), .src_take(src_take), .src_col(src_col),
    .src_eof(src_eof), .src_err(src_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [17:0] w);
    ctl_data = w; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rd(output logic [11:0] v);
    rd_en = 1'b1; v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_bit(input int b, input logic v);
    int n = 0;
    while (stat_word[b] !== v && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  localparam logic [36:0] VEC [0:5] = '{
    {18'o000005, 18'o000015, 1'b0},
    {18'o000105, 18'o200015, 1'b1},
    {18'o000405, 18'o600015, 1'b1},
    {18'o004003, 18'o600013, 1'b1},
    {18'o010007, 18'o000010, 1'b0},
    {18'o000002, 18'o000012, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", stat_word, 18'o000010);
    src_present = 1'b0; #1;
    chk("R1 hopper empty", stat_word, 18'o002000);
    src_present = 1'b1; #1;

    // R2 R3 R4 control table
    for (int i = 0; i < 6; i++) begin
      ctl(VEC[i][36:19]);
      chk("R2/R3/R4 status", stat_word, VEC[i][18:1]);
      chk("R2/R3/R4 irq", irq_req, VEC[i][0]);
      chk("R2 channel", irq_chan, VEC[i][21:19] & {3{~VEC[i][31]}});
    end

    // full card, prompt reads
    ctl(18'o001001);
    chk("R6 read command", stat_word, 18'o001001);
    for (int k = 0; k < 80; k++) begin
      wait_bit(6, 1'b1);
      if (k == 0) t0 = cyc;
      if (k == 1) begin
        t1 = cyc;
        chk("R7 interval", t1 - t0, PACE);
      end
      chk("R7 irq on column", irq_req, 1'b1);
      rd(v);
      chk("R7 column order", v, colv(k));
      if (k == 0) chk("R12 read clears ready", stat_word[6], 1'b0);
    end
    wait_bit(4, 1'b1);
    chk("R9 end of card", stat_word, 18'o000021);
    chk("R9 irq", irq_req, 1'b1);
    rd(v);
    chk("R12 empty read", v, 12'h000);
    chk("R12 pending cleared", irq_req, 1'b0);

    ctl(18'o000021);
    chk("R13 clear end card", stat_word, 18'o000011);
    ctl(18'o000101);
    chk("R5 ready irq", irq_req, 1'b1);

    // data miss
    ctl(18'o010000);
    chk("R4 clear", stat_word, 18'o000010);
    ctl(18'o001002);
    wait_bit(6, 1'b1);
    wait_bit(7, 1'b1);
    chk("R8 miss set", stat_word[7], 1'b1);
    rd(v);
    chk("R8 latest column", v, colv(1));
    chk("R8 sticky", stat_word[7], 1'b1);
    ctl(18'o000402);
    chk("R11 trouble irq", irq_req, 1'b1);
    ctl(18'o000202);
    chk("R8 miss clear", stat_word[7], 1'b0);
    wait_bit(6, 1'b1);
    ctl(18'o000012);
    chk("R13 clear data ready", stat_word[6], 1'b0);
    ctl(18'o010000);
    repeat (3 * PACE) @(negedge clk);
    chk("R4 cancel", stat_word, 18'o000010);

    // eof / error
    src_eof = 1'b1;
    ctl(18'o001000);
    wait_bit(5, 1'b1);
    chk("R10 eof", stat_word, 18'o000050);
    ctl(18'o010000);
    src_eof = 1'b0; src_err = 1'b1;
    ctl(18'o000403);
    ctl(18'o001403);
    wait_bit(8, 1'b1);
    chk("R10 error", stat_word, 18'o400413);
    chk("R11 trouble irq on error", irq_req, 1'b1);
    ctl(18'o010000);
    src_eof = 1'b1;
    ctl(18'o001000);
    wait_bit(5, 1'b1);
    chk("R10 eof wins", stat_word, 18'o000050);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule